// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Bank

This block is the host-facing register file of a network controller. It holds 64 registers of 16 bits each behind a simple read/write port. The port carries a byte address, and the register index is that address shifted right by a parameter. A write to the command register does two things: it records the requested operations as sticky command bits, and it emits one-cycle action pulses toward the transmit, receive, timer, resource and address-table engines. Those engines sit outside this block. They report back through done pulses, which clear their command bits, and through status-set pulses, which raise bits in the interrupt status register.

An interrupt line combines the status register with a mask register. Several registers keep only some bits of what the host writes. The two configuration registers accept writes only while the command register shows the reset state. The status register is cleared by writing ones. The revision register always reads a constant.

Top module: `nic_cmd_regbank`

## Requirements
- R1: The register index is the byte address `hostAddr` shifted right by `IDX_SHIFT` (default 1), keeping the low 6 bits. `hostRdData` shows the indexed register combinationally.
- R2: After reset, the command register (index 0x00) reads 0x0094, the interrupt mask (index 0x04) and the status register (index 0x05) read 0, the end-of-buffer count (index 0x13) reads 0x02F8, and `irq` is low.
- R3: The revision register (index 0x28) always reads 0x0004. Host writes to it have no effect.
- R4: A command write ORs `data & 0x03BF` into the command register. On the clock edge that takes the write, `actPulse[9:0]` is loaded with `data[9:0] & 0x3BF` and stays for one cycle. The bits are:
  - bit 0: halt
  - bit 1: transmit
  - bit 2: receiver off
  - bit 3: receiver on
  - bit 4: timer stop
  - bit 5: timer start
  - bit 7: soft reset
  - bit 8: resource read
  - bit 9: address-table load
- R5: If the command register has bit 7 set and a command write has bit 7 clear, bit 7 is cleared before the new bits are applied.
- R6: A command write with bit 7 set clears command bits 9, 8, 1 and 0, and sets bits 7 and 2.
- R7: Written bit 2 clears command bit 3, and written bit 3 clears command bit 2. Written bit 4 clears bit 5, and written bit 5 clears bit 4. These clears are applied in ascending order of the written bit, so writing both bits of a pair leaves both bits clear.
- R8: Pulses on `doneTx`, `doneRra` and `doneCam` clear command bits 1, 8 and 9 respectively. A command write in the same cycle is applied after the clear, so it can set the bit again.
- R9: `irq` is high exactly when `mask & status` is non-zero, and it follows register changes on the next cycle.
- R10: Writing ones to the status register clears those bits, and written zeros have no effect. `statusSet` ORs bits into the status register. A set wins over a same-cycle clear of the same bit.
- R11: The mask register stores `data & 0x7FFF`. The transmit-control register (index 0x03) stores `data & 0xF000`.
- R12: Configuration register 1 (index 0x01) stores `data & 0xBFFF`, and configuration register 2 (index 0x3F) stores `data & 0xF017`. Each accepts a write only while command bit 7 is set; otherwise the write is ignored.
- R13: All other registers store the full 16-bit written value and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Data of the addressed register |
| doneTx | input | 1 | Transmit engine finished |
| doneRra | input | 1 | Resource-read engine finished |
| doneCam | input | 1 | Address-table load finished |
| statusSet | input | 16 | Status bits to raise |
| actPulse | output | 10 | One-cycle action pulses, one per command bit |
| irq | output | 1 | Interrupt request |

## Verification
The command register is driven with several kinds of write:
- Single-bit writes show the OR and the pulse.
- A write of only the reserved bit 6 shows the 0x03BF mask.
- Writes of one bit or both bits of each opposing pair show the ordered cross-clears.
- Soft-reset writes, both from a running state and while already in reset, separate the reset clear-and-set from the leave-reset rule.

Done pulses are applied alone and together with a command write, which shows whether the clear or the write takes priority. Status traffic covers a set, a write of zeros, a write-one clear, and a set colliding with a clear. Mask changes then show that `irq` follows the masked status and not the raw status.

// File: rtl/nic_cmd_pkg.sv
`timescale 1ns/1ps
package nic_cmd_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_COUNT = 64;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int ACT_W     = 10;

  // command bit positions
  localparam int B_HALT  = 0;
  localparam int B_TX    = 1;
  localparam int B_RXOFF = 2;
  localparam int B_RXON  = 3;
  localparam int B_TSTOP = 4;
  localparam int B_TGO   = 5;
  localparam int B_SRST  = 7;
  localparam int B_RRD   = 8;
  localparam int B_TLOAD = 9;

  localparam logic [DATA_W-1:0] CMD_WMASK = 16'h03BF;
  localparam logic [DATA_W-1:0] CMD_RESET = 16'h0094;
  localparam logic [DATA_W-1:0] SRST_SET  = 16'h0084;
  localparam logic [DATA_W-1:0] SRST_CLR  = 16'h0303;

  // register indices
  localparam int IX_CMD  = 'h00;
  localparam int IX_CFG  = 'h01;
  localparam int IX_TXC  = 'h03;
  localparam int IX_MASK = 'h04;
  localparam int IX_STAT = 'h05;
  localparam int IX_EOB  = 'h13;
  localparam int IX_REV  = 'h28;
  localparam int IX_CFG2 = 'h3F;

  localparam logic [DATA_W-1:0] REV_VALUE = 16'h0004;
  localparam logic [DATA_W-1:0] EOB_RESET = 16'h02F8;

  typedef struct packed {
    logic              wrEn;   // masked store into the addressed register
    logic              clrEn;  // write-one-to-clear on the status register
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } hostOp_t;

  function automatic logic [DATA_W-1:0] wrMask(input int idx);
    case (idx)
      IX_MASK: wrMask = 16'h7FFF;
      IX_TXC:  wrMask = 16'hF000;
      IX_CFG:  wrMask = 16'hBFFF;
      IX_CFG2: wrMask = 16'hF017;
      default: wrMask = 16'hFFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    resetVal = (idx == IX_EOB) ? EOB_RESET : '0;
  endfunction
endpackage

// File: rtl/nic_cmd_ctrl.sv
`timescale 1ns/1ps
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic [DATA_W-1:0] hostData,
  input  logic              doneTx,
  input  logic              doneRra,
  input  logic              doneCam,
  output hostOp_t           hostOp,
  output logic [DATA_W-1:0] cmdValue,
  output logic [ACT_W-1:0]  actPulse
);
  localparam int N_DONE = 3;
  localparam int DONE_BIT [N_DONE] = '{B_TX, B_RRD, B_TLOAD};

  logic [DATA_W-1:0] cmdQ, cmdD, doneClr;
  logic [N_DONE-1:0] doneVec;
  logic wrCmd, isCfg, isLockedCfg, isStat, isRev;

  assign doneVec = {doneCam, doneRra, doneTx};

  for (genvar g = 0; g < N_DONE; g++) begin : g_done
    assign doneClr[DONE_BIT[g]] = doneVec[g];
  end
  assign doneClr[0]          = 1'b0;
  assign doneClr[7:2]        = '0;
  assign doneClr[DATA_W-1:10] = '0;

  assign wrCmd  = hostWr && (hostIdx == IDX_W'(IX_CMD));
  assign isStat = (hostIdx == IDX_W'(IX_STAT));
  assign isRev  = (hostIdx == IDX_W'(IX_REV));
  assign isCfg  = (hostIdx == IDX_W'(IX_CFG)) || (hostIdx == IDX_W'(IX_CFG2));
  assign isLockedCfg = isCfg && !cmdQ[B_SRST];

  always_comb begin
    hostOp.wrEn  = hostWr && !wrCmd && !isStat && !isRev && !isLockedCfg;
    hostOp.clrEn = hostWr && isStat;
    hostOp.idx   = hostIdx;
    hostOp.data  = hostData;
  end

  // command next state: engine clears first, then the host write in bit order
  always_comb begin
    cmdD = cmdQ & ~doneClr;
    if (wrCmd) begin
      if (cmdD[B_SRST] && !hostData[B_SRST]) cmdD[B_SRST] = 1'b0;
      cmdD = cmdD | (hostData & CMD_WMASK);
      if (hostData[B_RXOFF]) cmdD[B_RXON]  = 1'b0;
      if (hostData[B_RXON])  cmdD[B_RXOFF] = 1'b0;
      if (hostData[B_TSTOP]) cmdD[B_TGO]   = 1'b0;
      if (hostData[B_TGO])   cmdD[B_TSTOP] = 1'b0;
      if (hostData[B_SRST])  cmdD = (cmdD & ~SRST_CLR) | SRST_SET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_RESET;
      actPulse <= '0;
    end else begin
      cmdQ     <= cmdD;
      actPulse <= wrCmd ? (hostData[ACT_W-1:0] & CMD_WMASK[ACT_W-1:0]) : '0;
    end
  end

  assign cmdValue = cmdQ;

  // R6: soft reset leaves the reset state with engines idle
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && hostData[B_SRST]) |=>
      (cmdValue[B_SRST] && cmdValue[B_RXOFF] && !cmdValue[B_TX] &&
       !cmdValue[B_HALT] && !cmdValue[B_RRD] && !cmdValue[B_TLOAD]));

  // R4: pulses only follow a command write
  p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    (actPulse != '0) |-> $past(hostWr && (hostIdx == IDX_W'(IX_CMD))));

  // R8: transmit done clears the transmit bit when no write competes
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneTx && !wrCmd) |=> !cmdValue[B_TX]);
endmodule

// File: rtl/nic_cmd_datapath.sv
`timescale 1ns/1ps
module nic_cmd_datapath
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostOp_t           hostOp,
  input  logic [DATA_W-1:0] statusSet,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] cmdValue,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [DATA_W-1:0] bankQ [REG_COUNT];
  logic [DATA_W-1:0] clrBits;

  assign clrBits = hostOp.clrEn ? hostOp.data : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) bankQ[i] <= resetVal(i);
    end else begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (i == IX_STAT)
          bankQ[i] <= (bankQ[i] & ~clrBits) | statusSet;
        else if (hostOp.wrEn && (hostOp.idx == IDX_W'(i)))
          bankQ[i] <= hostOp.data & wrMask(i);
      end
    end
  end

  always_comb begin
    if (rdIdx == IDX_W'(IX_CMD))      rdData = cmdValue;
    else if (rdIdx == IDX_W'(IX_REV)) rdData = REV_VALUE;
    else                              rdData = bankQ[rdIdx];
  end

  assign irq = |(bankQ[IX_MASK] & bankQ[IX_STAT]);

  // R10: a raised status bit is present on the next cycle regardless of clears
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusSet != '0) |=> ((bankQ[IX_STAT] & $past(statusSet)) == $past(statusSet)));

  // R12: configuration registers only change while the reset bit was set
  p_cfg_lock_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((bankQ[IX_CFG] != $past(bankQ[IX_CFG])) || (bankQ[IX_CFG2] != $past(bankQ[IX_CFG2])))
      |-> $past(cmdValue[B_SRST]));

  // R9: interrupt can only rise after a register store or a status set
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(hostOp.wrEn || (statusSet != '0)));
endmodule

// File: rtl/nic_cmd_regbank.sv
`timescale 1ns/1ps
module nic_cmd_regbank
  import nic_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDX_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  input  logic              doneTx,
  input  logic              doneRra,
  input  logic              doneCam,
  input  logic [15:0]       statusSet,
  output logic [9:0]        actPulse,
  output logic              irq
);
  logic [IDX_W-1:0]  hostIdx;
  logic [DATA_W-1:0] cmdValue;
  hostOp_t           hostOp;

  assign hostIdx = IDX_W'(hostAddr >> IDX_SHIFT);

  nic_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWr   (hostWr),
    .hostIdx  (hostIdx),
    .hostData (hostWrData),
    .doneTx   (doneTx),
    .doneRra  (doneRra),
    .doneCam  (doneCam),
    .hostOp   (hostOp),
    .cmdValue (cmdValue),
    .actPulse (actPulse)
  );

  nic_cmd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostOp    (hostOp),
    .statusSet (statusSet),
    .rdIdx     (hostIdx),
    .cmdValue  (cmdValue),
    .rdData    (hostRdData),
    .irq       (irq)
  );

  // R1: reading the command index returns the live command state
  p_cmd_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hostIdx == IDX_W'(IX_CMD)) |-> (hostRdData == cmdValue));
endmodule

// File: tb/nic_cmd_regbank_test.sv
`timescale 1ns/1ps
module nic_cmd_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        doneTx = 1'b0, doneRra = 1'b0, doneCam = 1'b0;
  logic [15:0] statusSet = '0;
  logic [9:0]  actPulse;
  logic        irq;
  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  nic_cmd_regbank uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .doneTx(doneTx),
    .doneRra(doneRra), .doneCam(doneCam), .statusSet(statusSet),
    .actPulse(actPulse), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // one clock of stimulus, driven at a falling edge, released at the next
  task automatic cyc(input logic w, input logic [7:0] a, input logic [15:0] d,
                     input logic dT, input logic dR, input logic dC,
                     input logic [15:0] s);
    @(negedge clk);
    hostWr = w; hostAddr = a; hostWrData = d;
    doneTx = dT; doneRra = dR; doneCam = dC; statusSet = s;
    @(negedge clk);
    hostWr = 1'b0; doneTx = 1'b0; doneRra = 1'b0; doneCam = 1'b0; statusSet = '0;
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    cyc(1'b1, 8'(idx << 1), d, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic rdByte(input logic [7:0] a, output logic [15:0] v);
    hostAddr = a;
    #1;
    v = hostRdData;
  endtask

  task automatic rd(input int idx, output logic [15:0] v);
    rdByte(8'(idx << 1), v);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd('h00, v); chk("R2 command reset", v, 16'h0094);
    rd('h04, v); chk("R2 mask reset", v, 16'h0000);
    rd('h05, v); chk("R2 status reset", v, 16'h0000);
    rdByte(8'h26, v); chk("R2 end-of-buffer reset", v, 16'h02F8);
    rdByte(8'h27, v); chk("R1 odd byte address same index", v, 16'h02F8);
    rdByte(8'hA6, v); chk("R1 address bit above index ignored", v, 16'h02F8);
    chk("R2 irq low", {15'd0, irq}, 16'h0000);
    rd('h28, v); chk("R3 revision", v, 16'h0004);
  endtask

  task automatic t_rev;
    logic [15:0] v;
    wr('h28, 16'hFFFF);
    rd('h28, v); chk("R3 revision after write", v, 16'h0004);
  endtask

  task automatic t_cfgLock;
    logic [15:0] v;
    wr('h01, 16'hFFFF); rd('h01, v); chk("R12 cfg1 write in reset", v, 16'hBFFF);
    wr('h3F, 16'hFFFF); rd('h3F, v); chk("R12 cfg2 write in reset", v, 16'hF017);
    wr('h00, 16'h0000); rd('h00, v); chk("R5 leave reset", v, 16'h0014);
    chk("R4 no pulse for zero write", {6'd0, actPulse}, 16'h0000);
    wr('h01, 16'h0000); rd('h01, v); chk("R12 cfg1 locked", v, 16'hBFFF);
    wr('h3F, 16'h0000); rd('h3F, v); chk("R12 cfg2 locked", v, 16'hF017);
  endtask

  task automatic t_masks;
    logic [15:0] v;
    wr('h04, 16'hFFFF); rd('h04, v); chk("R11 mask bit 15 dropped", v, 16'h7FFF);
    wr('h03, 16'hFFFF); rd('h03, v); chk("R11 tx control upper nibble", v, 16'hF000);
    wr('h20, 16'hA5C3); rd('h20, v); chk("R13 plain register", v, 16'hA5C3);
    wr('h13, 16'h1111); rd('h13, v); chk("R13 end-of-buffer writable", v, 16'h1111);
  endtask

  task automatic t_cmdPulse;
    logic [15:0] v;
    wr('h00, 16'h0002);
    chk("R4 transmit pulse", {6'd0, actPulse}, 16'h0002);
    rd('h00, v); chk("R4 transmit sticky", v, 16'h0016);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", {6'd0, actPulse}, 16'h0000);
    wr('h00, 16'h0040);
    chk("R4 reserved bit no pulse", {6'd0, actPulse}, 16'h0000);
    rd('h00, v); chk("R4 reserved bit not stored", v, 16'h0016);
    wr('h00, 16'h0300);
    chk("R4 read and load pulses", {6'd0, actPulse}, 16'h0300);
    rd('h00, v); chk("R4 read and load sticky", v, 16'h0316);
  endtask

  task automatic t_done;
    logic [15:0] v;
    cyc(1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, '0);
    rd('h00, v); chk("R8 transmit done", v, 16'h0314);
    cyc(1'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b1, '0);
    rd('h00, v); chk("R8 read and load done", v, 16'h0014);
    cyc(1'b1, 8'h00, 16'h0002, 1'b1, 1'b0, 1'b0, '0);
    rd('h00, v); chk("R8 write beats same-cycle done", v, 16'h0016);
    cyc(1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, '0);
    rd('h00, v); chk("R8 done after rewrite", v, 16'h0014);
  endtask

  task automatic t_pairs;
    logic [15:0] v;
    wr('h00, 16'h0008); rd('h00, v); chk("R7 receiver on", v, 16'h0018);
    wr('h00, 16'h0020); rd('h00, v); chk("R7 timer start", v, 16'h0028);
    wr('h00, 16'h0004); rd('h00, v); chk("R7 receiver off", v, 16'h0024);
    wr('h00, 16'h0010); rd('h00, v); chk("R7 timer stop", v, 16'h0014);
    wr('h00, 16'h000C);
    chk("R7 both receiver pulses", {6'd0, actPulse}, 16'h000C);
    rd('h00, v); chk("R7 both receiver bits clear", v, 16'h0010);
  endtask

  task automatic t_softReset;
    logic [15:0] v;
    wr('h00, 16'h0302); rd('h00, v); chk("R6 setup", v, 16'h0312);
    wr('h00, 16'h0080);
    chk("R6 soft reset pulse", {6'd0, actPulse}, 16'h0080);
    rd('h00, v); chk("R6 soft reset state", v, 16'h0094);
    wr('h00, 16'h0001); rd('h00, v); chk("R5 halt leaves reset", v, 16'h0015);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    cyc(1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0080);
    rd('h05, v); chk("R10 status set", v, 16'h0080);
    chk("R9 irq with mask", {15'd0, irq}, 16'h0001);
    wr('h04, 16'h0000);
    chk("R9 irq masked off", {15'd0, irq}, 16'h0000);
    wr('h04, 16'h0080);
    chk("R9 irq unmasked", {15'd0, irq}, 16'h0001);
    wr('h05, 16'h0000); rd('h05, v); chk("R10 zero write keeps", v, 16'h0080);
    wr('h05, 16'h0080); rd('h05, v); chk("R10 one clears", v, 16'h0000);
    chk("R9 irq drops", {15'd0, irq}, 16'h0000);
    cyc(1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0300);
    cyc(1'b1, 8'h0A, 16'h0300, 1'b0, 1'b0, 1'b0, 16'h0100);
    rd('h05, v); chk("R10 set wins over clear", v, 16'h0100);
    chk("R9 irq stays low for unmasked bit", {15'd0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rev();
    t_cfgLock();
    t_masks();
    t_cmdPulse();
    t_done();
    t_pairs();
    t_softReset();
    t_irq();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule